// File: doc/BRIEF.md
# OTP Fuse Word Read Sequencer

This block reads a contiguous run of 32-bit words out of a one-time-programmable fuse macro without software stepping the macro's pins. A requester presents a first word index and a number of words. The engine accepts the request only while it is idle and acknowledges it one cycle later. It checks the request against the number of words the array holds. A request that fits powers the macro up one control at a time: deep standby, then trim, then enable. It then reads each word with a self-timed clock pulse, powers the macro down in the reverse order, and returns to idle.

Each word comes back on a single-cycle valid strobe together with its index. The strobe never waits on the consumer. A request that does not fit is acknowledged with an error flag and leaves every macro pin untouched. The clock high and low phases are specified in microseconds and scaled by a cycles-per-microsecond parameter. The defaults give 40 us high and 10 us low, and a bench can shrink them.

Top module: `otp_rd_seq`

## Requirements
- R1: While reset is held, and after it until a request is accepted, the standby, trim, enable and clock pins are 0, and req_ack and rd_valid are 0.
- R2: For an accepted request, fuse_dstb goes to 1 in the cycle req_ack is 1. fuse_trim goes to 1 one cycle later, and fuse_ce goes to 1 one cycle after that. Each control stays on while every later control is on.
- R3: For each word, fuse_addr carries the word index for at least one cycle before fuse_clk rises. fuse_addr then holds steady while fuse_clk stays at 1 for exactly T_ACCESS_US*CYC_PER_US cycles. fuse_clk is 1 only while fuse_ce is 1.
- R4: After the high phase, fuse_clk stays at 0 for T_LOW_US*CYC_PER_US cycles. The value on fuse_dout at the end of that low phase is presented on rd_data, with rd_valid at 1, in the next cycle.
- R5: fuse_ce drops in the cycle of the last word's rd_valid, or after power-up when the count is 0. fuse_trim drops one cycle later and fuse_dstb one cycle after that.
- R6: A request whose start index is at least TOTAL_WORDS, or whose start plus count is above TOTAL_WORDS, is acknowledged with req_err at 1 in the req_ack cycle. It drives no macro pin and produces no rd_valid.
- R7: An accepted request yields exactly req_count rd_valid pulses, each one cycle long. rd_index runs from req_start upward by one, and rd_index is always below TOTAL_WORDS. A count of 0 powers the macro up and down with no word.
- R8: req_vld is sampled only while the engine is idle. req_ack is a one-cycle pulse in the cycle after the accepting clock edge. A req_vld raised during a burst gets no acknowledge and causes no second burst once it has been withdrawn.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_vld | input | 1 | Request present |
| req_start | input | REQ_W | First word index |
| req_count | input | REQ_W | Number of words |
| req_ack | output | 1 | Request taken (one-cycle pulse) |
| req_err | output | 1 | Request rejected, valid with req_ack |
| fuse_dstb | output | 1 | Macro deep-standby control |
| fuse_trim | output | 1 | Macro trim enable |
| fuse_ce | output | 1 | Macro enable |
| fuse_clk | output | 1 | Macro read clock |
| fuse_addr | output | ADDR_W | Macro word address |
| fuse_dout | input | WORD_W | Macro data output |
| rd_valid | output | 1 | Word strobe |
| rd_data | output | WORD_W | Word read |
| rd_index | output | ADDR_W | Index of the word read |

## Verification
The acknowledge and error flag are due in the sample after the clock edge that saw req_vld in idle. The three power-up controls follow on that sample and the next two. The bench therefore checks the pin triple at three successive falling edges from the acknowledge. Each word strobe is due T_LO+1 samples after the clock falls, which is 1+T_HI+T_LO samples per word. A monitor counts the high and low samples of fuse_clk and compares them with the parameters. The power-down steps are checked on the strobe sample of the last word and the two samples after it. The fuse model drives a poison value while its clock is high, so a word captured in the wrong phase shows up as a data miscompare.

// File: rtl/otp_rd_pkg.sv
// Package otp_rd_pkg
// Shared sequencing state for the fuse read engine.
// Assumes: one state per macro control step; the pins are decoded from the state.
package otp_rd_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DSTB_ON,
        ST_TRIM_ON,
        ST_CE_ON,
        ST_ADDR,
        ST_HIGH,
        ST_LOW,
        ST_CE_OFF,
        ST_TRIM_OFF
    } seq_state_t;

endpackage

// File: rtl/otp_rd_range.sv
// Module otp_rd_range
// Decides whether a request runs past the end of the fuse array.
// Assumes: start and count are unsigned; a count of 0 is legal when start is in range.
module otp_rd_range #(
    parameter int TOTAL_WORDS = 4096,
    parameter int REQ_W       = 13
) (
    input  logic [REQ_W-1:0] start,
    input  logic [REQ_W-1:0] count,
    output logic             reject
);
    localparam logic [REQ_W:0] LIMIT = (REQ_W+1)'(TOTAL_WORDS);

    logic [REQ_W:0] run_end;

    // Purpose: form the exclusive end of the run and compare both ends with the array size.
    always_comb begin
        run_end = {1'b0, start} + {1'b0, count};
        reject  = ({1'b0, start} >= LIMIT) || (run_end > LIMIT);
    end

endmodule

// File: rtl/otp_rd_phase_timer.sv
// Module otp_rd_phase_timer
// Down counter that times the macro clock phases.
// Assumes: load_val is the phase length minus one; expired is high in the last cycle of a phase.
module otp_rd_phase_timer #(
    parameter int TMR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [TMR_W-1:0] load_val,
    output logic             expired
);
    logic [TMR_W-1:0] cnt_q;

    // Purpose: load a phase length, or count down to zero and hold there.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

    AST_TIMER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q == '0) |=> (cnt_q == '0));  // R4

endmodule

// File: rtl/otp_rd_seq.sv
// Module otp_rd_seq
// Reads a run of fuse words. It powers the macro up one control at a time, pulses the
// macro clock with timed high and low phases for each word, and powers the macro down
// in the reverse order. Requests that run past the array are refused without touching pins.
// Assumes: the macro presents valid data once its clock has been low for the low phase;
// the consumer of rd_valid never stalls.
module otp_rd_seq #(
    parameter int WORD_W      = 32,
    parameter int TOTAL_WORDS = 4096,
    parameter int CYC_PER_US  = 200,
    parameter int T_ACCESS_US = 40,
    parameter int T_LOW_US    = 10,
    localparam int ADDR_W     = (TOTAL_WORDS > 1) ? $clog2(TOTAL_WORDS) : 1,
    localparam int REQ_W      = $clog2(TOTAL_WORDS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_vld,
    input  logic [REQ_W-1:0]  req_start,
    input  logic [REQ_W-1:0]  req_count,
    output logic              req_ack,
    output logic              req_err,
    output logic              fuse_dstb,
    output logic              fuse_trim,
    output logic              fuse_ce,
    output logic              fuse_clk,
    output logic [ADDR_W-1:0] fuse_addr,
    input  logic [WORD_W-1:0] fuse_dout,
    output logic              rd_valid,
    output logic [WORD_W-1:0] rd_data,
    output logic [ADDR_W-1:0] rd_index
);
    import otp_rd_pkg::*;

    localparam int T_HI   = T_ACCESS_US * CYC_PER_US;
    localparam int T_LO   = T_LOW_US * CYC_PER_US;
    localparam int T_MAX  = (T_HI > T_LO) ? T_HI : T_LO;
    localparam int TMR_W  = $clog2(T_MAX + 1);

    seq_state_t        state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic [REQ_W-1:0]  left_q;
    logic              ack_q, err_q, vld_q;
    logic [WORD_W-1:0] data_q;
    logic [ADDR_W-1:0] idx_q;

    logic              reject;
    logic              accept;
    logic              tmr_load;
    logic [TMR_W-1:0]  tmr_val;
    logic              tmr_done;
    logic              word_end;

    otp_rd_range #(
        .TOTAL_WORDS (TOTAL_WORDS),
        .REQ_W       (REQ_W)
    ) u_range (
        .start  (req_start),
        .count  (req_count),
        .reject (reject)
    );

    otp_rd_phase_timer #(
        .TMR_W (TMR_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_done)
    );

    assign accept   = (state_q == ST_IDLE) && req_vld;
    assign word_end = (state_q == ST_LOW) && tmr_done;

    // Purpose: load the high phase on leaving the address step and the low phase at the end of the high phase.
    always_comb begin
        tmr_load = (state_q == ST_ADDR) || ((state_q == ST_HIGH) && tmr_done);
        tmr_val  = (state_q == ST_ADDR) ? TMR_W'(T_HI - 1) : TMR_W'(T_LO - 1);
    end

    // Purpose: step through power-up, the per-word clock phases and power-down.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (req_vld && !reject) state_d = ST_DSTB_ON;
            ST_DSTB_ON:  state_d = ST_TRIM_ON;
            ST_TRIM_ON:  state_d = ST_CE_ON;
            ST_CE_ON:    state_d = (left_q == '0) ? ST_CE_OFF : ST_ADDR;
            ST_ADDR:     state_d = ST_HIGH;
            ST_HIGH:     if (tmr_done) state_d = ST_LOW;
            ST_LOW:      if (tmr_done) state_d = (left_q == REQ_W'(1)) ? ST_CE_OFF : ST_ADDR;
            ST_CE_OFF:   state_d = ST_TRIM_OFF;
            ST_TRIM_OFF: state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // Purpose: hold the sequencing state.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Purpose: latch the run on acceptance and advance the address and remaining count per word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            left_q <= '0;
        end else if (accept && !reject) begin
            addr_q <= req_start[ADDR_W-1:0];
            left_q <= req_count;
        end else if (word_end) begin
            addr_q <= addr_q + 1'b1;
            left_q <= left_q - 1'b1;
        end
    end

    // Purpose: acknowledge a sampled request and flag a refusal in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_q <= 1'b0;
            err_q <= 1'b0;
        end else begin
            ack_q <= accept;
            err_q <= accept && reject;
        end
    end

    // Purpose: capture the macro output at the end of the low phase and strobe it for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q  <= 1'b0;
            data_q <= '0;
            idx_q  <= '0;
        end else begin
            vld_q <= word_end;
            if (word_end) begin
                data_q <= fuse_dout;
                idx_q  <= addr_q;
            end
        end
    end

    // Purpose: decode the macro pins from the sequencing state.
    always_comb begin
        fuse_dstb = (state_q != ST_IDLE);
        fuse_trim = (state_q != ST_IDLE) && (state_q != ST_DSTB_ON) && (state_q != ST_TRIM_OFF);
        fuse_ce   = (state_q == ST_CE_ON) || (state_q == ST_ADDR) ||
                    (state_q == ST_HIGH)  || (state_q == ST_LOW);
        fuse_clk  = (state_q == ST_HIGH);
        fuse_addr = fuse_ce ? addr_q : '0;
    end

    assign req_ack  = ack_q;
    assign req_err  = err_q;
    assign rd_valid = vld_q;
    assign rd_data  = data_q;
    assign rd_index = idx_q;

    AST_CLK_NEEDS_CE: assert property (@(posedge clk) disable iff (!rst_n)
        fuse_clk |-> fuse_ce);  // R3
    AST_CE_NEEDS_TRIM: assert property (@(posedge clk) disable iff (!rst_n)
        fuse_ce |-> (fuse_trim && fuse_dstb));  // R2
    AST_TRIM_NEEDS_DSTB: assert property (@(posedge clk) disable iff (!rst_n)
        fuse_trim |-> fuse_dstb);  // R5
    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (fuse_clk && $past(fuse_clk)) |-> $stable(fuse_addr));  // R3
    AST_ERR_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        req_err |-> req_ack);  // R6
    AST_REJECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_err |-> (!fuse_dstb && !fuse_trim && !fuse_ce));  // R6
    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);  // R7
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (int'(rd_index) < TOTAL_WORDS));  // R7

endmodule

// File: tb/otp_rd_seq_bench.sv
module otp_rd_seq_bench;

    localparam int WORD_W = 32;
    localparam int TOTAL  = 48;
    localparam int CPU    = 2;
    localparam int ACC_US = 3;
    localparam int LOW_US = 2;
    localparam int T_HI   = ACC_US * CPU;
    localparam int T_LO   = LOW_US * CPU;
    localparam int ADDR_W = $clog2(TOTAL);
    localparam int REQ_W  = $clog2(TOTAL + 1);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_vld = 1'b0;
    logic [REQ_W-1:0]  req_start = '0;
    logic [REQ_W-1:0]  req_count = '0;
    logic              req_ack, req_err;
    logic              fuse_dstb, fuse_trim, fuse_ce, fuse_clk;
    logic [ADDR_W-1:0] fuse_addr;
    logic [WORD_W-1:0] fuse_dout;
    logic              rd_valid;
    logic [WORD_W-1:0] rd_data;
    logic [ADDR_W-1:0] rd_index;

    int n_chk = 0;
    int n_bad = 0;
    int cur_idx = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    otp_rd_seq #(
        .WORD_W      (WORD_W),
        .TOTAL_WORDS (TOTAL),
        .CYC_PER_US  (CPU),
        .T_ACCESS_US (ACC_US),
        .T_LOW_US    (LOW_US)
    ) u_otp_rd_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_vld   (req_vld),
        .req_start (req_start),
        .req_count (req_count),
        .req_ack   (req_ack),
        .req_err   (req_err),
        .fuse_dstb (fuse_dstb),
        .fuse_trim (fuse_trim),
        .fuse_ce   (fuse_ce),
        .fuse_clk  (fuse_clk),
        .fuse_addr (fuse_addr),
        .fuse_dout (fuse_dout),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data),
        .rd_index  (rd_index)
    );

    function automatic logic [31:0] fmodel(input int a);
        return (32'(a) * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
    endfunction

    // Fuse macro model: address latched on the clock rise, poison while the clock is high.
    logic [ADDR_W-1:0] lat_addr = '0;
    always @(posedge fuse_clk) lat_addr <= fuse_addr;
    assign fuse_dout = fuse_clk ? 32'hDEAD_BEEF : fmodel(int'(lat_addr));

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int pins();
        return {29'd0, fuse_dstb, fuse_trim, fuse_ce};
    endfunction

    // Phase-length and address monitor (R3, R4).
    int hi_cnt = 0;
    int lo_cnt = 0;
    bit in_low = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (fuse_clk) begin
                hi_cnt++;
                check(int'(fuse_addr) == cur_idx, "R3 addr during high", int'(fuse_addr), cur_idx);
            end else begin
                if (hi_cnt > 0) begin
                    check(hi_cnt == T_HI, "R3 high phase length", hi_cnt, T_HI);
                    hi_cnt = 0;
                    in_low = 1'b1;
                    lo_cnt = 0;
                end
                if (in_low) begin
                    if (rd_valid) begin
                        check(lo_cnt == T_LO, "R4 low phase length", lo_cnt, T_LO);
                        in_low = 1'b0;
                    end else begin
                        lo_cnt++;
                    end
                end
            end
        end
    end

    task automatic run_req(input int start, input int count, input bit poke);
        bit exp_rej;
        int words;
        int guard;
        exp_rej = (start >= TOTAL) || (start + count > TOTAL);
        @(negedge clk);
        req_start = REQ_W'(start);
        req_count = REQ_W'(count);
        req_vld   = 1'b1;
        @(negedge clk);
        check(req_ack == 1'b1, "R8 ack one cycle after request", int'(req_ack), 1);
        req_vld = 1'b0;
        check(req_err == exp_rej, "R6 error flag", int'(req_err), int'(exp_rej));
        if (exp_rej) begin
            for (int k = 0; k < 4; k++) begin
                check(pins() == 0, "R6 pins untouched", pins(), 0);
                check(!rd_valid, "R6 no word", int'(rd_valid), 0);
                @(negedge clk);
            end
            return;
        end
        check(pins() == 3'b100, "R2 standby first", pins(), 3'b100);
        @(negedge clk);
        check(pins() == 3'b110, "R2 trim second", pins(), 3'b110);
        @(negedge clk);
        check(pins() == 3'b111, "R2 enable third", pins(), 3'b111);
        cur_idx = start;
        words = 0;
        guard = 0;
        forever begin
            @(negedge clk);
            guard++;
            if (poke && words == 1 && guard > 3) begin
                if (req_vld) req_vld = 1'b0;
                else if (!rd_valid) begin req_vld = 1'b1; poke = 1'b0; end
            end else if (req_vld) req_vld = 1'b0;
            check(!req_ack, "R8 no ack while busy", int'(req_ack), 0);
            if (rd_valid) begin
                check(rd_data == fmodel(cur_idx), "R4 word data", int'(rd_data), int'(fmodel(cur_idx)));
                check(int'(rd_index) == cur_idx, "R7 word index order", int'(rd_index), cur_idx);
                cur_idx++;
                words++;
            end
            if (pins() == 3'b110 || guard > 5000) break;
        end
        req_vld = 1'b0;
        check(words == count, "R7 word count", words, count);
        @(negedge clk);
        check(pins() == 3'b100, "R5 trim released second", pins(), 3'b100);
        @(negedge clk);
        check(pins() == 3'b000, "R5 standby released last", pins(), 3'b000);
        check(!req_ack, "R8 withdrawn request ignored", int'(req_ack), 0);
        @(negedge clk);
        check(!req_ack && pins() == 0, "R8 no second burst", pins(), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(pins() == 0 && !fuse_clk, "R1 pins in reset", pins(), 0);
        check(!req_ack && !rd_valid, "R1 strobes in reset", int'(rd_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(pins() == 0 && !req_ack && !rd_valid, "R1 idle after reset", pins(), 0);

        run_req(0, 3, 1'b0);
        run_req(TOTAL - 1, 1, 1'b0);
        run_req(TOTAL - 1, 2, 1'b0);
        run_req(TOTAL, 0, 1'b0);
        run_req(0, 0, 1'b0);
        run_req(TOTAL - 8, 8, 1'b0);
        run_req(5, 4, 1'b1);

        void'($urandom(32'd1234));
        for (int i = 0; i < 24; i++) begin
            int s, c;
            s = int'($urandom % 56);
            c = int'($urandom % 12);
            run_req(s, c, 1'b0);
        end

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule